// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is the receiving end of a three-wire serial audio link on which the block is the slave. An external master drives a bit clock, a frame-sync line and a serial data line. The block samples all three in its own system clock domain, finds the word boundaries under the framing rule that is selected, and produces one parallel left sample and one parallel right sample for each stereo frame. Three framings are covered: I2S, left-justified, and a DSP framing in which frame-sync is a single-bit-clock pulse.

Configuration is static and is changed only while the link is quiet: the framing, the word length, the data delay used in DSP framing, and a rate/enable field. All serial decoding happens on the rising edges of the bit clock, which are detected after a two-flop synchroniser. For this reason the system clock must run at least four times faster than the bit clock. Each completed stereo pair is shown on registered outputs together with a single-cycle strobe.

Top module: `audio_serial_rx`

## Requirements
- R1: During and after reset, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: With `cfg_fmt`=0 (I2S), every change of frame-sync starts a word whose MSB is sampled on the second rising bit-clock edge on which the new frame-sync level is seen. Frame-sync low marks the left word and high marks the right word.
- R3: With `cfg_fmt`=1 (left-justified), every change of frame-sync starts a word whose MSB is sampled on the first rising bit-clock edge on which the new level is seen. Frame-sync high marks the left word and low marks the right word.
- R4: With `cfg_fmt`=2 (DSP), a frame starts on the rising edge that first sees frame-sync high. The left MSB is sampled on that edge when `cfg_dsp_delay`=0, or on the next edge when it is 1. The right word follows the left LSB on the very next edge.
- R5: `cfg_wlen` selects the word length as 0→8, 1→16, 2→20, 3→24 bits. Bits arrive MSB first. Each word is placed left-aligned in the 24-bit output, and the low bits it does not fill are zero.
- R6: Bit-clock edges that come after a word's LSB and before the next frame event have no effect on any output.
- R7: While `cfg_rate` is zero the block is disabled: `valid_o` stays low and both sample outputs hold their values.
- R8: `valid_o` is high for exactly one system clock, five system clocks after the bit-clock rise that carries the right LSB. The two sample outputs change only in that cycle and are updated together.
- R9: A frame event that arrives before the current word is complete discards the partial word. Reception restarts cleanly on the new frame.
- R10: A right word produces no output unless a left word has completed since the last output or since the block was enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 DSP |
| cfg_wlen | input | 2 | Word length code (8/16/20/24 bits) |
| cfg_dsp_delay | input | 1 | DSP framing: MSB one edge after the frame pulse |
| cfg_rate | input | RATE_W | Rate/enable setting; zero disables |
| bclk_i | input | 1 | Bit clock from the external master |
| fsync_i | input | 1 | Frame-sync from the external master |
| sdata_i | input | 1 | Serial audio data |
| left_o | output | SAMPLE_W | Left sample, left-aligned |
| right_o | output | SAMPLE_W | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
The bench drives filler ones in every delay slot and every idle slot. A design that starts the MSB one edge early or one edge late, or that keeps shifting after the LSB, therefore returns corrupted or shifted samples. Frames are cut short in the middle of the left word (DSP) and in the middle of the right word (I2S). A receiver that kept the partial word would then emit a stray pair or a merged one. A right word with no left word in front of it, and a whole frame sent while disabled, must both leave the strobe low and the outputs unchanged. Word lengths of 8 and 16 bits with all-ones data show any mistake in the zero-filling or the alignment shift.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_DSP = 2'd2
  } fmt_e;

  localparam int unsigned MAX_WLEN = 24;

  // word length code to number of bits
  function automatic int unsigned wlen_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 20;
      default: return MAX_WLEN;
    endcase
  endfunction

endpackage

// File: rtl/audio_rx_sync.sv
module audio_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/audio_rx_edge.sv
module audio_rx_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic fs_i,
  input  logic sd_i,
  output logic rise_o,
  output logic fs_o,
  output logic sd_o
);

  logic sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      rise_o <= 1'b0;
      fs_o   <= 1'b0;
      sd_o   <= 1'b0;
    end else begin
      sclk_d <= sclk_i;
      rise_o <= sclk_i & ~sclk_d;
      fs_o   <= fs_i;
      sd_o   <= sd_i;
    end
  end

endmodule

// File: rtl/audio_rx_engine.sv
module audio_rx_engine
  import audio_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          wlen_i,
  input  logic                dsp_delay_i,
  input  logic                rise_i,
  input  logic                fs_i,
  input  logic                sd_i,
  output logic                done_o,
  output logic                done_right_o,
  output logic [SAMPLE_W-1:0] word_o
);

  localparam int CNT_W = $clog2(SAMPLE_W + 1);

  logic                fs_prev_q;
  logic                active_q;
  logic                right_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [SAMPLE_W-1:0] sh_q;

  logic [CNT_W-1:0]    nbits;
  logic [CNT_W-1:0]    shamt;
  logic [CNT_W-1:0]    cnt_nx;
  logic [SAMPLE_W-1:0] sh_nx;
  logic                evt;
  logic                evt_right;
  logic                lead;

  always_comb begin
    nbits  = CNT_W'(wlen_bits(wlen_i));
    shamt  = CNT_W'(SAMPLE_W) - nbits;
    sh_nx  = {sh_q[SAMPLE_W-2:0], sd_i};
    cnt_nx = cnt_q + 1'b1;
    case (fmt_i)
      FMT_I2S: begin
        evt       = fs_i ^ fs_prev_q;
        evt_right = fs_i;
        lead      = 1'b1;
      end
      FMT_DSP: begin
        evt       = fs_i & ~fs_prev_q;
        evt_right = 1'b0;
        lead      = dsp_delay_i;
      end
      default: begin
        evt       = fs_i ^ fs_prev_q;
        evt_right = ~fs_i;
        lead      = 1'b0;
      end
    endcase
  end

  // frame-sync level seen on the previous bit-clock rise
  always_ff @(posedge clk) begin
    if (rst)         fs_prev_q <= 1'b0;
    else if (rise_i) fs_prev_q <= fs_i;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      active_q     <= 1'b0;
      right_q      <= 1'b0;
      cnt_q        <= '0;
      sh_q         <= '0;
      done_o       <= 1'b0;
      done_right_o <= 1'b0;
      word_o       <= '0;
    end else begin
      done_o <= 1'b0;
      if (rise_i) begin
        if (evt) begin
          // new frame event: any partial word is dropped
          active_q <= 1'b1;
          right_q  <= evt_right;
          if (lead) begin
            cnt_q <= '0;
            sh_q  <= '0;
          end else begin
            cnt_q <= CNT_W'(1);
            sh_q  <= {{(SAMPLE_W-1){1'b0}}, sd_i};
          end
        end else if (active_q) begin
          if (cnt_nx == nbits) begin
            done_o       <= 1'b1;
            done_right_o <= right_q;
            word_o       <= sh_nx << shamt;
            cnt_q        <= '0;
            sh_q         <= '0;
            if (fmt_i == FMT_DSP && !right_q) right_q  <= 1'b1;
            else                              active_q <= 1'b0;
          end else begin
            cnt_q <= cnt_nx;
            sh_q  <= sh_nx;
          end
        end
      end
    end
  end

  // R6: no word is completed from an idle state
  a_r6_idle_no_word: assert property (@(posedge clk) disable iff (rst)
    !active_q |=> !done_o);

  // R9: a frame event restarts the shift counter
  a_r9_event_restart: assert property (@(posedge clk) disable iff (rst)
    (en_i && rise_i && evt) |=> (active_q && cnt_q <= CNT_W'(1)));

  // R4: in DSP framing the right word follows the left one at once
  a_r4_dsp_chain: assert property (@(posedge clk) disable iff (rst)
    (done_o && !done_right_o && fmt_i == FMT_DSP) |-> (active_q && right_q));

endmodule

// File: rtl/audio_rx_pair.sv
module audio_rx_pair #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic                done_i,
  input  logic                done_right_i,
  input  logic [SAMPLE_W-1:0] word_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  logic [SAMPLE_W-1:0] hold_q;
  logic                have_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      have_q  <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!en_i) begin
        have_q <= 1'b0;
      end else if (done_i) begin
        if (!done_right_i) begin
          hold_q <= word_i;
          have_q <= 1'b1;
        end else if (have_q) begin
          left_o  <= hold_q;
          right_o <= word_i;
          valid_o <= 1'b1;
          have_q  <= 1'b0;
        end
      end
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r8_left_holds: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(left_o));

  a_r8_right_holds: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(right_o));

  a_r7_quiet_disabled: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !valid_o);

  a_r10_need_left: assert property (@(posedge clk) disable iff (rst)
    (done_i && done_right_i && !have_q) |=> !valid_o);

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int SAMPLE_W    = 24,
  parameter int RATE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_fmt,
  input  logic [1:0]          cfg_wlen,
  input  logic                cfg_dsp_delay,
  input  logic [RATE_W-1:0]   cfg_rate,
  input  logic                bclk_i,
  input  logic                fsync_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  localparam int LINES = 3;

  logic [LINES-1:0]    synced;
  logic                rise;
  logic                fs_s;
  logic                sd_s;
  logic                en;
  logic                done;
  logic                done_right;
  logic [SAMPLE_W-1:0] word;

  assign en = (cfg_rate != '0);

  audio_rx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sdata_i, fsync_i, bclk_i}),
    .q_o (synced)
  );

  audio_rx_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .sclk_i (synced[0]),
    .fs_i   (synced[1]),
    .sd_i   (synced[2]),
    .rise_o (rise),
    .fs_o   (fs_s),
    .sd_o   (sd_s)
  );

  audio_rx_engine #(.SAMPLE_W(SAMPLE_W)) u_engine (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en),
    .fmt_i        (cfg_fmt),
    .wlen_i       (cfg_wlen),
    .dsp_delay_i  (cfg_dsp_delay),
    .rise_i       (rise),
    .fs_i         (fs_s),
    .sd_i         (sd_s),
    .done_o       (done),
    .done_right_o (done_right),
    .word_o       (word)
  );

  audio_rx_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en),
    .done_i       (done),
    .done_right_i (done_right),
    .word_i       (word),
    .left_o       (left_o),
    .right_o      (right_o),
    .valid_o      (valid_o)
  );

  // R1: outputs quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!valid_o && left_o == '0 && right_o == '0));

endmodule

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [1:0]  cfg_fmt = 2'd0;
  logic [1:0]  cfg_wlen = 2'd3;
  logic        cfg_dsp_delay = 1'b0;
  logic [3:0]  cfg_rate = 4'd0;
  logic        bclk = 1'b0;
  logic        fsync = 1'b0;
  logic        sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  audio_serial_rx dut_i (
    .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen),
    .cfg_dsp_delay(cfg_dsp_delay), .cfg_rate(cfg_rate),
    .bclk_i(bclk), .fsync_i(fsync), .sdata_i(sdata),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  int q_cyc[$];
  logic [23:0] q_l[$];
  logic [23:0] q_r[$];
  logic [23:0] cur_l = '0;
  logic [23:0] cur_r = '0;
  logic last_fs = 1'b0;
  bit run_checks = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req,
                       input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: expected strobe and held outputs, every clock
  bit ev;
  always @(negedge clk) begin
    if (run_checks) begin
      ev = 0;
      while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
        void'(q_cyc.pop_front()); void'(q_l.pop_front()); void'(q_r.pop_front());
      end
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        ev = 1;
        void'(q_cyc.pop_front());
        cur_l = q_l.pop_front();
        cur_r = q_r.pop_front();
      end
      check(valid_o == ev, {cur_req, "/R8 valid"}, {23'b0, valid_o}, {23'b0, ev});
      check(left_o == cur_l, {cur_req, " left"}, left_o, cur_l);
      check(right_o == cur_r, {cur_req, " right"}, right_o, cur_r);
    end
  end

  function automatic int nbits_of(input logic [1:0] code);
    return (code == 2'd0) ? 8 : (code == 2'd1) ? 16 : (code == 2'd2) ? 20 : 24;
  endfunction

  function automatic logic [23:0] align(input logic [23:0] w, input int nb);
    logic [23:0] m;
    m = (24'h1 << nb) - 24'h1;
    return (w & m) << (24 - nb);
  endfunction

  // one bit-clock period of 8 system clocks; data changes while low
  task automatic bit_cycle(input logic f, input logic d, input bit mark,
                           input logic [23:0] el, input logic [23:0] er);
    @(negedge clk);
    bclk = 1'b0; fsync = f; sdata = d; last_fs = f;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    if (mark) begin
      q_cyc.push_back(cyc + 5); q_l.push_back(el); q_r.push_back(er);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input logic [23:0] lv, input logic [23:0] rv,
                            input int idle, input int trunc, input bit expect_out);
    logic fq[$];
    logic dq[$];
    int last = -1;
    int nb = nbits_of(cfg_wlen);
    int dl;
    logic lvl_l;
    logic [23:0] w;
    if (cfg_fmt == 2'd2) begin
      dl = int'(cfg_dsp_delay);
      if (last_fs) begin fq.push_back(1'b0); dq.push_back(1'b0); end
      for (int i = 0; i < dl + 2*nb + idle; i++) begin
        fq.push_back(i == 0);
        if (i < dl || i >= dl + 2*nb) dq.push_back(1'b1);
        else if (i < dl + nb)         dq.push_back(lv[nb-1-(i-dl)]);
        else                          dq.push_back(rv[nb-1-(i-dl-nb)]);
        if (i == dl + 2*nb - 1) last = fq.size() - 1;
      end
    end else begin
      dl    = (cfg_fmt == 2'd0) ? 1 : 0;
      lvl_l = (cfg_fmt == 2'd0) ? 1'b0 : 1'b1;
      if (last_fs == lvl_l) begin fq.push_back(!lvl_l); dq.push_back(1'b0); end
      for (int h = 0; h < 2; h++) begin
        w = (h == 1) ? rv : lv;
        for (int i = 0; i < dl + nb + idle; i++) begin
          fq.push_back((h == 1) ? !lvl_l : lvl_l);
          if (i < dl || i >= dl + nb) dq.push_back(1'b1);
          else                        dq.push_back(w[nb-1-(i-dl)]);
          if (h == 1 && i == dl + nb - 1) last = fq.size() - 1;
        end
      end
    end
    for (int k = 0; k < fq.size(); k++) begin
      if (trunc > 0 && k >= trunc) break;
      bit_cycle(fq[k], dq[k], expect_out && trunc == 0 && k == last,
                align(lv, nb), align(rv, nb));
    end
  endtask

  task automatic set_cfg(input logic [1:0] f, input logic [1:0] wl, input logic dd);
    repeat (4) @(negedge clk);
    cfg_fmt = f; cfg_wlen = wl; cfg_dsp_delay = dd;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid in reset", {23'b0, valid_o}, 24'h0);
    check(left_o == 24'h0, "R1 left in reset", left_o, 24'h0);
    check(right_o == 24'h0, "R1 right in reset", right_o, 24'h0);
    rst = 1'b0;
    run_checks = 1;
    repeat (5) @(negedge clk);
    cfg_rate = 4'd3;

    cur_req = "R2/R5";
    set_cfg(2'd0, 2'd3, 1'b0);
    send_frame(24'hA5C3F1, 24'h5A3C0E, 0, 0, 1);
    send_frame(24'h800001, 24'h7FFFFE, 2, 0, 1);
    set_cfg(2'd0, 2'd1, 1'b0);
    send_frame(24'h00BEEF, 24'h001234, 3, 0, 1);

    cur_req = "R3/R5";
    set_cfg(2'd1, 2'd2, 1'b0);
    send_frame(24'h0ABCDE, 24'h054321, 1, 0, 1);
    set_cfg(2'd1, 2'd0, 1'b0);
    send_frame(24'h0000FF, 24'h00005A, 2, 0, 1);

    cur_req = "R4/R5";
    set_cfg(2'd2, 2'd1, 1'b0);
    send_frame(24'h00C0DE, 24'h00F00D, 2, 0, 1);
    set_cfg(2'd2, 2'd3, 1'b1);
    send_frame(24'h123456, 24'hFEDCBA, 0, 0, 1);
    set_cfg(2'd2, 2'd0, 1'b1);
    send_frame(24'h000081, 24'h00007E, 5, 0, 1);

    cur_req = "R6";
    set_cfg(2'd1, 2'd1, 1'b0);
    send_frame(24'h00FFFF, 24'h000001, 6, 0, 1);

    cur_req = "R9";
    set_cfg(2'd2, 2'd1, 1'b0);
    send_frame(24'h00AAAA, 24'h005555, 0, 6, 0);
    send_frame(24'h003C3C, 24'h00C3C3, 1, 0, 1);
    set_cfg(2'd0, 2'd1, 1'b0);
    send_frame(24'h001111, 24'h002222, 0, 22, 0);
    send_frame(24'h007777, 24'h008888, 0, 0, 1);

    cur_req = "R10";
    set_cfg(2'd1, 2'd0, 1'b0);
    bit_cycle(1'b1, 1'b1, 0, '0, '0);
    for (int i = 0; i < 10; i++) bit_cycle(1'b0, (i % 3 == 0), 0, '0, '0);
    send_frame(24'h0000A1, 24'h0000B2, 0, 0, 1);

    cur_req = "R7";
    set_cfg(2'd0, 2'd1, 1'b0);
    cfg_rate = 4'd0;
    repeat (4) @(negedge clk);
    send_frame(24'h00DEAD, 24'h00BEEF, 1, 0, 0);
    check(left_o == cur_l, "R7 left held while disabled", left_o, cur_l);
    cfg_rate = 4'd9;
    repeat (4) @(negedge clk);
    send_frame(24'h004242, 24'h002424, 0, 0, 1);

    repeat (20) @(negedge clk);
    check(q_cyc.size() == 0, "R8 expected pairs not delivered",
          24'(q_cyc.size()), 24'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule